// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block is a small programmable logic cell. It takes eighteen data inputs and produces four outputs. A configuration image sets up an array of product terms. Twenty of those terms feed four output functions. Three more terms serve as control: one clears the output registers asynchronously, one qualifies their clock, and one drives an output-enable line toward the pad logic.

Each output can take one of two paths. The short path ORs four fixed terms. The wide path ORs any chosen subset of the twenty sum terms and can XOR the result with one dedicated term. Either path can then be inverted and presented combinationally or through a register. That register loads on every global clock edge, or only on edges where the clock term is true.

The configuration is loaded as 32-bit words through a plain write strobe. A low `rst_n` clears the whole image, so a fresh cell drives all outputs low until it is programmed.

Top module: `plc_block`

## Requirements
- R1: While `rst_n` is low, and after its release until the first configuration write, the image is all zero, `dout` is 0 and `oe` is 0, whatever `din` carries.
- R2: When `cfg_we` is high at a rising `clk` edge, `cfg_wdata` is stored as word `cfg_addr`. Word w holds image bits [32w+31:32w]. The image is 928 bits long, in 29 words, and every other word keeps its value.
- R3: Product term k (k = 0..22) is configured by image bits [36k+35:36k]. Bit 2i selects din[i] and bit 2i+1 selects ~din[i]. The term is true when at least one literal is selected and every selected literal is true. A term with no literal selected is false, and a term that selects both polarities of one input is always false.
- R4: Output o is configured by the 25-bit field at image bit 828+25o. When field bit 0 (short path) is set, the pre-inversion value is the OR of terms 5o..5o+3, and the share bits and the XOR bit have no effect.
- R5: With field bit 0 clear, the pre-inversion value is the OR of every sum term j (0..19) whose share bit, field bit 5+j, is set. When field bit 1 is set, that OR is XORed with term 5o+4.
- R6: Field bit 2 inverts the value chosen by R4 or R5.
- R7: With field bit 3 clear, `dout[o]` follows `din` with no clock. With it set, `dout[o]` takes the value present at a rising `clk` edge and holds it until the next loading edge.
- R8: With field bit 4 set, a registered output loads only on rising edges where term 21 is true, and holds otherwise.
- R9: While term 20 is true, all output registers clear at once, without a clock, and stay clear. They reload at the first loading edge after it falls. A low `rst_n` also clears them at once.
- R10: `oe` equals term 22 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Active-low asynchronous reset of image and registers |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_addr | input | 5 | Configuration word index |
| cfg_wdata | input | 32 | Configuration word data |
| din | input | 18 | Logic inputs |
| dout | output | 4 | Logic outputs |
| oe | output | 1 | Output enable from the control term |

## Verification
Assertions check on every cycle that a configuration write lands in the addressed word, and that a low reset or a true clear term leaves the registers at zero. They also check that a globally clocked cell captures its function value at each edge, and that a cell on the qualified clock holds while the clock term is false. The logic functions themselves, the short-path and wide-path selection, cross-group term sharing, inversion, and the clear that acts between edges can be shown only by the bench. It applies chosen input patterns under chosen images and compares the outputs with values worked out by hand.

// File: rtl/plc_pkg.sv
package plc_pkg;

    // Per-output cell mode; bit 0 is the short-path select.
    typedef struct packed {
        logic ptclk;   // bit 4: clock qualified by the clock term
        logic regd;    // bit 3: registered output
        logic inv;     // bit 2: output inversion
        logic xor_en;  // bit 1: XOR with the cell's dedicated term
        logic bypass;  // bit 0: four-term short path
    } cell_mode_t;

    localparam int MODE_W    = $bits(cell_mode_t);
    localparam int N_CTRL_PT = 3;
    localparam int CTRL_RST  = 0;
    localparam int CTRL_CLK  = 1;
    localparam int CTRL_OE   = 2;

endpackage

// File: rtl/plc_cfg_store.sv
module plc_cfg_store #(
    parameter int CFG_W    = 32,
    parameter int N_WORDS  = 29,
    parameter int CFG_BITS = 928,
    parameter int AW       = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_BITS-1:0] cfg_bits
);

    localparam int FLAT_W = N_WORDS * CFG_W;

    logic [CFG_W-1:0]  words_d [N_WORDS];
    logic [CFG_W-1:0]  words_q [N_WORDS];
    logic [FLAT_W-1:0] flat;

    always_comb begin
        for (int w = 0; w < N_WORDS; w++) begin
            words_d[w] = words_q[w];
        end
        if (cfg_we && (int'(cfg_addr) < N_WORDS)) begin
            words_d[cfg_addr] = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < N_WORDS; w++) begin
                words_q[w] <= '0;
            end
        end else begin
            for (int w = 0; w < N_WORDS; w++) begin
                words_q[w] <= words_d[w];
            end
        end
    end

    always_comb begin
        for (int w = 0; w < N_WORDS; w++) begin
            flat[w*CFG_W +: CFG_W] = words_q[w];
        end
    end

    assign cfg_bits = flat[CFG_BITS-1:0];

    // R2: an accepted write is visible in the addressed word one edge later
    a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_addr) < N_WORDS)) |=>
            (words_q[$past(cfg_addr)] == $past(cfg_wdata)));

endmodule

// File: rtl/plc_and_array.sv
module plc_and_array #(
    parameter int N_IN = 18,
    parameter int N_PT = 23
) (
    input  logic [N_IN-1:0]        din,
    input  logic [N_PT*2*N_IN-1:0] cfg_pt,
    output logic [N_PT-1:0]        pt
);

    localparam int PT_W = 2 * N_IN;

    logic [PT_W-1:0] lit;

    // Literal k*2 is the true input, k*2+1 its complement.
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[2*i]   = din[i];
        assign lit[2*i+1] = ~din[i];
    end

    for (genvar k = 0; k < N_PT; k++) begin : g_pt
        logic [PT_W-1:0] mask;
        assign mask  = cfg_pt[k*PT_W +: PT_W];
        assign pt[k] = (|mask) & (&(lit | ~mask));
    end

endmodule

// File: rtl/plc_sum_path.sv
module plc_sum_path #(
    parameter int N_OUT      = 4,
    parameter int PT_PER_OUT = 5,
    parameter int BYP_PT     = 4
) (
    input  logic [N_OUT*PT_PER_OUT-1:0]       pt_sum,
    input  logic [N_OUT*N_OUT*PT_PER_OUT-1:0] share,
    input  logic [N_OUT-1:0]                  byp_v,
    input  logic [N_OUT-1:0]                  xor_v,
    input  logic [N_OUT-1:0]                  inv_v,
    output logic [N_OUT-1:0]                  comb
);

    localparam int N_SUM = N_OUT * PT_PER_OUT;
    localparam int XPT   = PT_PER_OUT - 1;

    for (genvar o = 0; o < N_OUT; o++) begin : g_cell
        logic [PT_PER_OUT-1:0] own;
        logic                  short_v;
        logic                  wide_v;
        assign own     = pt_sum[o*PT_PER_OUT +: PT_PER_OUT];
        assign short_v = |own[BYP_PT-1:0];
        assign wide_v  = (|(pt_sum & share[o*N_SUM +: N_SUM])) ^ (xor_v[o] & own[XPT]);
        assign comb[o] = (byp_v[o] ? short_v : wide_v) ^ inv_v[o];
    end

endmodule

// File: rtl/plc_out_cells.sv
module plc_out_cells #(
    parameter int N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pt_rst,
    input  logic             pt_clk,
    input  logic [N_OUT-1:0] comb,
    input  logic [N_OUT-1:0] regd_v,
    input  logic [N_OUT-1:0] ptclk_v,
    output logic [N_OUT-1:0] dout
);

    typedef struct packed {
        logic [N_OUT-1:0] q;
    } cell_state_t;

    cell_state_t st_d;
    cell_state_t st_q;
    logic        clr;

    assign clr = ~rst_n | pt_rst;

    always_comb begin
        st_d = st_q;
        for (int o = 0; o < N_OUT; o++) begin
            if (!ptclk_v[o] || pt_clk) begin
                st_d.q[o] = comb[o];
            end
        end
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        assign dout[o] = regd_v[o] ? st_q.q[o] : comb[o];

        // R7: global-clock cells capture the function value at the edge
        a_r7_global_load: assert property (@(posedge clk) disable iff (clr)
            (!ptclk_v[o] && !pt_rst) |=> (st_q.q[o] == $past(comb[o])));

        // R8: qualified-clock cells hold while the clock term is false
        a_r8_ptclk_hold: assert property (@(posedge clk) disable iff (clr)
            (ptclk_v[o] && !pt_clk && !pt_rst) |=> $stable(st_q.q[o]));
    end

    // R1: registers read zero whenever the global reset is low
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |-> (st_q.q == '0));

    // R9: registers read zero whenever the clear term is true
    a_r9_ptrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rst |-> (st_q.q == '0));

endmodule

// File: rtl/plc_block.sv
module plc_block #(
    parameter int N_IN       = 18,
    parameter int N_OUT      = 4,
    parameter int PT_PER_OUT = 5,
    parameter int BYP_PT     = 4,
    parameter int CFG_W      = 32,
    localparam int N_SUM     = N_OUT * PT_PER_OUT,
    localparam int N_PT      = N_SUM + plc_pkg::N_CTRL_PT,
    localparam int PT_W      = 2 * N_IN,
    localparam int OCW       = plc_pkg::MODE_W + N_SUM,
    localparam int PT_BITS   = N_PT * PT_W,
    localparam int CFG_BITS  = PT_BITS + N_OUT * OCW,
    localparam int N_WORDS   = (CFG_BITS + CFG_W - 1) / CFG_W,
    localparam int AW        = $clog2(N_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [N_IN-1:0]  din,
    output logic [N_OUT-1:0] dout,
    output logic             oe
);

    import plc_pkg::*;

    logic [CFG_BITS-1:0]    cfg_bits;
    logic [N_PT-1:0]        pt;
    logic [N_OUT*N_SUM-1:0] share;
    logic [N_OUT-1:0]       byp_v, xor_v, inv_v, regd_v, ptclk_v;
    logic [N_OUT-1:0]       comb;
    cell_mode_t             modes [N_OUT];

    plc_cfg_store #(
        .CFG_W    (CFG_W),
        .N_WORDS  (N_WORDS),
        .CFG_BITS (CFG_BITS),
        .AW       (AW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_bits  (cfg_bits)
    );

    plc_and_array #(
        .N_IN (N_IN),
        .N_PT (N_PT)
    ) u_and (
        .din    (din),
        .cfg_pt (cfg_bits[PT_BITS-1:0]),
        .pt     (pt)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_cfg
        localparam int BASE = PT_BITS + o * OCW;
        assign modes[o]                = cell_mode_t'(cfg_bits[BASE +: MODE_W]);
        assign share[o*N_SUM +: N_SUM] = cfg_bits[BASE + MODE_W +: N_SUM];
        assign byp_v[o]                = modes[o].bypass;
        assign xor_v[o]                = modes[o].xor_en;
        assign inv_v[o]                = modes[o].inv;
        assign regd_v[o]               = modes[o].regd;
        assign ptclk_v[o]              = modes[o].ptclk;
    end

    plc_sum_path #(
        .N_OUT      (N_OUT),
        .PT_PER_OUT (PT_PER_OUT),
        .BYP_PT     (BYP_PT)
    ) u_sum (
        .pt_sum (pt[N_SUM-1:0]),
        .share  (share),
        .byp_v  (byp_v),
        .xor_v  (xor_v),
        .inv_v  (inv_v),
        .comb   (comb)
    );

    plc_out_cells #(
        .N_OUT (N_OUT)
    ) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .pt_rst  (pt[N_SUM + CTRL_RST]),
        .pt_clk  (pt[N_SUM + CTRL_CLK]),
        .comb    (comb),
        .regd_v  (regd_v),
        .ptclk_v (ptclk_v),
        .dout    (dout)
    );

    // R10: output enable comes straight from its control term
    assign oe = pt[N_SUM + CTRL_OE];

endmodule

// File: tb/plc_block_tb.sv
module plc_block_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_IN     = 18;
    localparam int CFG_W    = 32;
    localparam int PT_W     = 36;
    localparam int OCW      = 25;
    localparam int PT_BITS  = 828;
    localparam int CFG_BITS = 928;
    localparam int N_WORDS  = 29;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [4:0]        cfg_addr = '0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [N_IN-1:0]   din = '0;
    logic [3:0]        dout;
    logic              oe;

    int n_checks = 0;
    int n_fail   = 0;
    logic [CFG_BITS-1:0] img;

    always #(CLK_PERIOD/2) clk = ~clk;

    plc_block u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .din       (din),
        .dout      (dout),
        .oe        (oe)
    );

    typedef struct packed {
        logic [N_IN-1:0] v;
        logic [3:0]      q;
        logic            e;
    } vec_t;

    // Image A: out0 short path (t0=in0&in1, t1=~in2, t2=in11&~in11, t3 empty,
    // share t5 and xor t4=in5 ignored); out1 = (t0|t5=in3)^t9(in4);
    // out2 = ~(in6&~in7); out3 registered = in17&in8; oe = in9.
    localparam vec_t VECS [8] = '{
        '{18'd0,                                                    4'b0101, 1'b0},
        '{(18'd1<<0)|(18'd1<<1)|(18'd1<<2),                         4'b0111, 1'b0},
        '{(18'd1<<2)|(18'd1<<4),                                    4'b0110, 1'b0},
        '{(18'd1<<2)|(18'd1<<3)|(18'd1<<4)|(18'd1<<11),             4'b0100, 1'b0},
        '{(18'd1<<2)|(18'd1<<6)|(18'd1<<9),                         4'b0000, 1'b1},
        '{(18'd1<<2)|(18'd1<<6)|(18'd1<<7)|(18'd1<<8)|(18'd1<<17),  4'b1100, 1'b0},
        '{(18'd1<<0)|(18'd1<<2)|(18'd1<<5)|(18'd1<<8),              4'b0100, 1'b0},
        '{(18'd1<<0)|(18'd1<<1)|(18'd1<<2)|(18'd1<<3)|(18'd1<<4)|(18'd1<<8)|(18'd1<<9)|(18'd1<<11)|(18'd1<<17),
                                                                    4'b1101, 1'b1}
    };

    localparam logic [N_IN-1:0] B8  = 18'd1 << 8;
    localparam logic [N_IN-1:0] B10 = 18'd1 << 10;
    localparam logic [N_IN-1:0] B15 = 18'd1 << 15;
    localparam logic [N_IN-1:0] B16 = 18'd1 << 16;
    localparam logic [N_IN-1:0] B17 = 18'd1 << 17;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic add_lit(input int pt, input int inp, input bit neg);
        img[pt*PT_W + 2*inp + int'(neg)] = 1'b1;
    endtask

    task automatic set_mode(input int o, input bit byp, input bit xr, input bit inv,
                            input bit regd, input bit ptclk);
        int base;
        base = PT_BITS + o*OCW;
        img[base+0] = byp;
        img[base+1] = xr;
        img[base+2] = inv;
        img[base+3] = regd;
        img[base+4] = ptclk;
    endtask

    task automatic add_share(input int o, input int pt);
        img[PT_BITS + o*OCW + 5 + pt] = 1'b1;
    endtask

    task automatic write_word(input int w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 5'(w);
        cfg_wdata = img[w*CFG_W +: CFG_W];
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all R) actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state with all inputs high
        repeat (3) @(posedge clk);
        @(negedge clk) din = '1;
        #1;
        chk("R1 dout in reset", 32'(dout), 32'h0);
        chk("R1 oe in reset", 32'(oe), 32'h0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk) #1;
        chk("R1 dout unconfigured", 32'(dout), 32'h0);
        chk("R1 oe unconfigured", 32'(oe), 32'h0);

        // Build image A (R3 literal encoding, R4/R5 field layout)
        img = '0;
        add_lit(0, 0, 0); add_lit(0, 1, 0);
        add_lit(1, 2, 1);
        add_lit(2, 11, 0); add_lit(2, 11, 1);
        add_lit(4, 5, 0);
        add_lit(5, 3, 0);
        add_lit(9, 4, 0);
        add_lit(10, 6, 0); add_lit(10, 7, 1);
        add_lit(15, 17, 0); add_lit(15, 8, 0);
        add_lit(20, 15, 0); add_lit(20, 16, 0);
        add_lit(21, 10, 0);
        add_lit(22, 9, 0);
        set_mode(0, 1, 1, 0, 0, 0); add_share(0, 5);
        set_mode(1, 0, 1, 0, 0, 0); add_share(1, 5); add_share(1, 0);
        set_mode(2, 0, 0, 1, 0, 0); add_share(2, 10);
        set_mode(3, 0, 0, 0, 1, 0); add_share(3, 15);
        din = '0;
        for (int w = 0; w < N_WORDS; w++) write_word(w);

        // Table: R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) din = VECS[i].v;
            @(posedge clk) #1;
            chk($sformatf("R3/R4/R5/R6/R7 vec%0d dout", i), 32'(dout), 32'(VECS[i].q));
            chk($sformatf("R10 vec%0d oe", i), 32'(oe), 32'(VECS[i].e));
        end

        // R7: registered output holds between edges
        @(negedge clk) din = B8 | B17;
        @(posedge clk) #1;
        chk("R7 capture", 32'(dout[3]), 32'h1);
        @(negedge clk) din = B17;
        #1;
        chk("R7 hold before edge", 32'(dout[3]), 32'h1);
        @(posedge clk) #1;
        chk("R7 update at edge", 32'(dout[3]), 32'h0);

        // R9: clear term acts without a clock
        @(negedge clk) din = B8 | B17;
        @(posedge clk) #1;
        chk("R9 preload", 32'(dout[3]), 32'h1);
        @(negedge clk) din = B8 | B17 | B15 | B16;
        #1;
        chk("R9 async clear", 32'(dout[3]), 32'h0);
        @(posedge clk) #1;
        chk("R9 clear held over edge", 32'(dout[3]), 32'h0);
        @(negedge clk) din = B8 | B17;
        #1;
        chk("R9 no reload before edge", 32'(dout[3]), 32'h0);
        @(posedge clk) #1;
        chk("R9 reload after release", 32'(dout[3]), 32'h1);

        // R2/R6: rewrite one word to invert out0
        img[PT_BITS + 2] = 1'b1;
        din = '0;
        write_word((PT_BITS + 2) / CFG_W);
        #1;
        chk("R2/R6 inverted out0 vec0", 32'(dout[0]), 32'h0);
        @(negedge clk) din = VECS[2].v;
        #1;
        chk("R6 inverted out0 vec2", 32'(dout[0]), 32'h1);
        chk("R2 other cells untouched", 32'(dout[2:1]), 32'h3);

        // R8: qualified clock on out3
        set_mode(3, 0, 0, 0, 1, 1);
        din = '0;
        write_word((PT_BITS + 3*OCW) / CFG_W);
        @(negedge clk) din = B10;
        @(posedge clk) #1;
        chk("R8 load zero", 32'(dout[3]), 32'h0);
        @(negedge clk) din = B8 | B17;
        @(posedge clk) #1;
        chk("R8 hold with clock term low", 32'(dout[3]), 32'h0);
        @(negedge clk) din = B8 | B17 | B10;
        @(posedge clk) #1;
        chk("R8 load with clock term high", 32'(dout[3]), 32'h1);
        @(negedge clk) din = '0;
        @(posedge clk) #1;
        chk("R8 hold one", 32'(dout[3]), 32'h1);
        @(negedge clk) din = B10;
        @(posedge clk) #1;
        chk("R8 reload zero", 32'(dout[3]), 32'h0);

        // R1/R9: global reset mid-run clears registers and image
        @(negedge clk) din = B8 | B17 | B10;
        @(posedge clk) #1;
        chk("R9 preload before global reset", 32'(dout[3]), 32'h1);
        @(negedge clk) begin
            rst_n = 1'b0;
            din   = VECS[7].v;
        end
        #1;
        chk("R9 global reset clears", 32'(dout), 32'h0);
        chk("R1 oe cleared", 32'(oe), 32'h0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk) #1;
        chk("R1 image cleared", 32'(dout), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule